// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that runs from the peripheral clock. A programmable 8-bit prescaler divides the clock by a value from 1 to 256. A fixed divider then divides the result by 16, 32, 64 or 128. Each pulse that comes out of the divider is one tick, and each tick decrements a 16-bit count register. Software sets up the block through a small register port with a write strobe, a 2-bit address, write data and combinational read data.

The count register starts from whatever value software writes into it. Turning the timer on does not load anything into it. If a tick arrives while the count is zero, the block treats this as expiry: it reloads the count from the reload register and keeps counting. On expiry the block can set a sticky interrupt, start a fixed-length reset pulse, or do both. While the core reports debug through `dbg_ack`, no reset pulse is started.

Address map: 0 is control, 1 is reload data, 2 is count, and 3 is interrupt clear/status.

Top module: `wdog_timer`

## Requirements
- R1: After reset, count and reload both read 0x8000, and control reads 0. `irq_o` and `rst_req_o` are both low.
- R2: The control register holds the prescaler P in bits [15:8] and the divider select S in bits [4:3] (00=16, 01=32, 10=64, 11=128). While bit [5] (run) is set, one tick occurs every (P+1)*16*2^S clock cycles, and each tick that finds a nonzero count decrements it by one.
- R3: Setting the run bit leaves the count register unchanged. The reload value is not copied into the count.
- R4: A tick that finds the count at zero is an expiry. It loads the count from the reload register (address 1), and counting continues from that value.
- R5: When control bit [2] is set, an expiry sets `irq_o`. `irq_o` stays high until any write to address 3 clears it. With bit [2] clear, an expiry leaves `irq_o` low. Address 3 reads back the flag in bit 0.
- R6: When control bit [0] is set, an expiry raises `rst_req_o` for exactly 128 clock cycles, starting the cycle after the expiring tick. With bit [0] clear, `rst_req_o` stays low.
- R7: An expiry that occurs while `dbg_ack` is high starts no reset pulse. The interrupt behaves as usual.
- R8: While the run bit is clear, the count holds its value and the prescaler and divider are held at zero. The first tick after run is set therefore comes one full tick period later.
- R9: A software write to address 1 or 2 takes effect on the next cycle and reads back unchanged. Control reads back bits [15:8], [5:2] and [0], with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_ack | input | 1 | Core reports debug; blocks the reset pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
A prescaler or divider that counts wrong changes the tick period. The bench finds this by measuring the cycle of the first decrement after run is set, for every divider select and several prescaler values, so a bad count shows within one tick period. A wrong reload or expiry condition shows at the count readback and at `irq_o` on the edge of the expiring tick. A bad pulse counter shows as a wrong length of `rst_req_o`, found within 128 cycles. A run gate that leaks shows as a count that drifts while the timer is stopped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int PSC_W = 8;
    localparam int DIV_W = 7;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_RELOAD = 2'd1,
        ADDR_COUNT  = 2'd2,
        ADDR_IRQCLR = 2'd3
    } wd_addr_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             run;
        logic [1:0]       div_sel;
        logic             irq_en;
        logic             rst_en;
    } wd_ctrl_t;

    function automatic wd_ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        wd_ctrl_t c;
        c.psc     = w[15:8];
        c.run     = w[5];
        c.div_sel = w[4:3];
        c.irq_en  = w[2];
        c.rst_en  = w[0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input wd_ctrl_t c);
        return {c.psc, 2'b00, c.run, c.div_sel, c.irq_en, 1'b0, c.rst_en};
    endfunction

    function automatic logic [DIV_W-1:0] div_last(input logic [1:0] sel);
        logic [DIV_W-1:0] r;
        case (sel)
            2'd0:    r = 7'd15;
            2'd1:    r = 7'd31;
            2'd2:    r = 7'd63;
            default: r = 7'd127;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    input  logic [1:0]       div_sel,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;
    logic [DIV_W-1:0] dcnt_q;
    logic [DIV_W-1:0] dlast;
    logic             pwrap;
    logic             dwrap;

    assign dlast = div_last(div_sel);
    assign pwrap = (pcnt_q >= psc);
    assign dwrap = (dcnt_q >= dlast);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
            dcnt_q <= '0;
        end else if (pwrap) begin
            pcnt_q <= '0;
            dcnt_q <= dwrap ? '0 : dcnt_q + 1'b1;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    assign tick = run && pwrap && dwrap;
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = 16'h8000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RST_VAL;
        else if (ld)
            cnt_q <= ld_val;
        else if (tick)
            cnt_q <= at_zero ? reload_val : cnt_q - 1'b1;
    end

    assign count  = cnt_q;
    assign expire = tick && at_zero;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (trig)
            left_q <= CW'(LEN);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int               RST_LEN = 128,
    parameter logic [REG_W-1:0] CNT_RST = 16'h8000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dbg_ack,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_o,
    output logic             rst_req_o
);
    wd_ctrl_t         ctrl_q;
    logic [REG_W-1:0] reload_q;
    logic [REG_W-1:0] count;
    logic             irq_q;
    logic             tick;
    logic             expire;
    logic             wr_ctrl, wr_reload, wr_count, wr_clr;
    logic             pulse_trig;

    assign wr_ctrl   = wr_en && (addr == ADDR_CTRL);
    assign wr_reload = wr_en && (addr == ADDR_RELOAD);
    assign wr_count  = wr_en && (addr == ADDR_COUNT);
    assign wr_clr    = wr_en && (addr == ADDR_IRQCLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= CNT_RST;
        end else begin
            if (wr_ctrl)   ctrl_q   <= ctrl_unpack(wr_data);
            if (wr_reload) reload_q <= wr_data;
        end
    end

    wdog_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .psc     (ctrl_q.psc),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    wdog_downcount #(.W(REG_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .ld         (wr_count),
        .ld_val     (wr_data),
        .reload_val (reload_q),
        .count      (count),
        .expire     (expire)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (expire && ctrl_q.irq_en)
            irq_q <= 1'b1;
        else if (wr_clr)
            irq_q <= 1'b0;
    end

    assign pulse_trig = expire && ctrl_q.rst_en && !dbg_ack;

    wdog_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trig   (pulse_trig),
        .active (rst_req_o)
    );

    assign irq_o = irq_q;

    always_comb begin
        case (addr)
            ADDR_CTRL:   rd_data = ctrl_pack(ctrl_q);
            ADDR_RELOAD: rd_data = reload_q;
            ADDR_COUNT:  rd_data = count;
            default:     rd_data = {{(REG_W-1){1'b0}}, irq_q};
        endcase
    end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        dbg_ack,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [15:0] wr_data,
    input logic        run,
    input logic        tick,
    input logic        expire,
    input logic [15:0] count,
    input logic [15:0] reload,
    input logic        irq,
    input logic        rst_req
);
    logic wr_cnt, wr_clr;
    assign wr_cnt = wr_en && (addr == 2'd2);
    assign wr_clr = wr_en && (addr == 2'd3);

    a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick && count != 16'd0 && !wr_cnt) |=> (count == $past(count) - 16'd1));

    a_r3_no_load_on_start: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && wr_data[5] && !run) |=> $stable(count));

    a_r4_reload_on_expiry: assert property (@(posedge clk) disable iff (rst)
        (expire && !wr_cnt) |=> (count == $past(reload)));

    a_r5_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_clr) |=> irq);

    a_r7_debug_blocks_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(!dbg_ack));

    a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(count));
endmodule

bind wdog_timer wdog_timer_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .dbg_ack (dbg_ack),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .run     (ctrl_q.run),
    .tick    (tick),
    .expire  (expire),
    .count   (count),
    .reload  (reload_q),
    .irq     (irq_o),
    .rst_req (rst_req_o)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_ack = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        irq_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdog_timer dut_i (
        .clk(clk), .rst(rst), .dbg_ack(dbg_ack), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int k, hi;
        bit seen;
        int psc_set[3] = '{0, 1, 3};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, v); check(v == 16'h8000, "R1 count", v, 16'h8000);
        rd(2'd1, v); check(v == 16'h8000, "R1 reload", v, 16'h8000);
        rd(2'd0, v); check(v == 16'h0000, "R1 ctrl", v, 0);
        check(!irq_o && !rst_req_o, "R1 outputs", {irq_o, rst_req_o}, 0);

        // R9 readback
        wr(2'd1, 16'h1234); rd(2'd1, v); check(v == 16'h1234, "R9 reload rb", v, 16'h1234);
        wr(2'd2, 16'hBEEF); rd(2'd2, v); check(v == 16'hBEEF, "R9 count rb", v, 16'hBEEF);
        wr(2'd0, 16'hFFFF); rd(2'd0, v); check(v == 16'hFF3D, "R9 ctrl rb", v, 16'hFF3D);
        wr(2'd0, 16'h0000);

        // R2 tick period sweep over prescaler and divider select
        foreach (psc_set[i]) begin
            for (int s = 0; s < 4; s++) begin
                int expn;
                expn = (psc_set[i] + 1) * (16 << s);
                wr(2'd0, 16'h0000);
                wr(2'd2, 16'd5);
                wr(2'd0, 16'((psc_set[i] << 8) | (s << 3) | 16'h20));
                k = 0;
                do begin
                    @(negedge clk); k++;
                    rd(2'd2, v);
                end while (v == 16'd5 && k < 2000);
                check(k == expn && v == 16'd4, "R2 tick period", k, expn);
            end
        end
        wr(2'd0, 16'h0000);

        // R3 enabling does not load reload
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd9);
        wr(2'd0, 16'h0020);
        rd(2'd2, v); check(v == 16'd9, "R3 no load on start", v, 9);
        wr(2'd0, 16'h0000);

        // R4/R5 count sequence, expiry reload, irq
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'h0024);
        waitn(16); rd(2'd2, v); check(v == 16'd1, "R4 first dec", v, 1);
        waitn(16); rd(2'd2, v); check(v == 16'd0, "R4 at zero", v, 0);
        waitn(15); rd(2'd2, v); check(v == 16'd0 && !irq_o, "R5 irq before expiry", {irq_o, v}, 0);
        waitn(1);  rd(2'd2, v); check(v == 16'd4, "R4 reload", v, 4);
        check(irq_o, "R5 irq set", irq_o, 1);
        waitn(16); rd(2'd2, v); check(v == 16'd3, "R4 continue", v, 3);
        rd(2'd3, v); check(v == 16'd1, "R5 status rb", v, 1);
        waitn(40); check(irq_o, "R5 irq held", irq_o, 1);
        wr(2'd3, 16'h0000);
        check(!irq_o, "R5 irq cleared", irq_o, 0);
        wr(2'd0, 16'h0000);

        // R5 irq disabled
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0020);
        waitn(16); rd(2'd2, v);
        check(v == 16'd4 && !irq_o, "R5 no irq when disabled", irq_o, 0);
        wr(2'd0, 16'h0000);

        // R6 reset pulse length
        wr(2'd1, 16'h0100);
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0021);
        waitn(15); check(!rst_req_o, "R6 no early pulse", rst_req_o, 0);
        waitn(1);  check(rst_req_o, "R6 pulse start", rst_req_o, 1);
        hi = 0;
        while (rst_req_o && hi < 1000) begin hi++; @(negedge clk); end
        check(hi == 128, "R6 pulse length", hi, 128);
        wr(2'd0, 16'h0000);

        // R6 no pulse when reset disabled
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0020);
        seen = 0;
        for (int j = 0; j < 40; j++) begin @(negedge clk); if (rst_req_o) seen = 1; end
        check(!seen, "R6 disabled no pulse", seen, 0);
        wr(2'd0, 16'h0000);

        // R7 debug suppresses reset, irq still works
        dbg_ack = 1'b1;
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0025);
        seen = 0;
        for (int j = 0; j < 40; j++) begin @(negedge clk); if (rst_req_o) seen = 1; end
        check(!seen, "R7 reset suppressed", seen, 0);
        check(irq_o, "R7 irq still set", irq_o, 1);
        wr(2'd0, 16'h0000);
        dbg_ack = 1'b0;
        wr(2'd3, 16'h0000);

        // R8 stop holds count and restarts prescaler
        wr(2'd2, 16'd7);
        wr(2'd0, 16'h0020);
        waitn(10);
        wr(2'd0, 16'h0000);
        waitn(40); rd(2'd2, v); check(v == 16'd7, "R8 count held", v, 7);
        wr(2'd0, 16'h0020);
        waitn(15); rd(2'd2, v); check(v == 16'd7, "R8 no early tick", v, 7);
        waitn(1);  rd(2'd2, v); check(v == 16'd6, "R8 full period", v, 6);
        wr(2'd0, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule